// File: doc/BRIEF.md
# I2C Master Repeated-Start Sequencer

This block takes an I2C master that already owns the bus through a repeated start without putting a stop condition on the wire. When a restart is requested it first lets go of both lines, with SDA left high so that no stop condition appears. Other devices therefore still regard the bus as busy. It then waits until the line is seen to be free and until the last bit sampled on an SCL rising edge reads high. After that it counts out a minimum setup interval and drives a fresh start condition. It ends by shifting out the slave address byte, most significant bit first.

The controller keeps a four-bit flag word, {master, transmit, bus-busy, pending}, with master in bit 3 and pending in bit 0. It also keeps an acknowledge-mode bit and a byte register that holds the address together with the direction bit. A plain start request is accepted only while master mode is off, and takes the same wait, delay and start path without the release step. A restart request is accepted only while master mode is on; otherwise it is ignored. All timing is counted in periods of an external `tick` strobe. Both lines are driven as open-drain enables, and the sampled line levels come back on `scl_in` and `sda_in`.

Top module: `i2c_restart_seq`

## Requirements
- R1: After reset, `busy` is 0, both open-drain enables are 0, `ctrl_flags` is 4'b0001, `ack_mode` is 0, `bus_busy` is 0 and `lrb` is 1.
- R2: A `restart_req` while the master flag (bit 3) is 0 is ignored: `busy` stays 0, `ctrl_flags` and both line enables keep their values.
- R3: Two clock edges after an accepted restart request, `ctrl_flags` reads 4'b0001 and both enables are 0. No stop condition appears, so `bus_busy` stays 1.
- R4: While `bus_busy` is 1 and `scl_in` is 0 (SCL held low by another device), no start condition is generated.
- R5: `lrb` takes the SDA level at each SCL rising edge. While it is 0 the sequencer does not proceed to a start.
- R6: SDA falls for the start no sooner than SETUP_NS after both lines were last seen high. Any drop of either line during the delay restarts it.
- R7: By the time of the start condition, `ack_mode` is 1 and `data_byte` equals `addr_byte`.
- R8: The start is SDA going low while SCL is high, and at that moment `ctrl_flags` becomes 4'b1111.
- R9: SCL stays high for at least HOLD_NS after SDA falls, and then it is pulled low.
- R10: Exactly 8 bits are presented on SDA at SCL rising edges after the start, and they equal `addr_byte`, MSB first.
- R11: `busy` is 1 from the cycle after an accepted request until completion. On completion the pending flag (bit 0) is 0, giving `ctrl_flags` = 4'b1110, and SCL is left held low.
- R12: A `start_req` with master off generates a start and sends the address with no release step.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timebase strobe, one pulse per TICK_NS |
| start_req | input | 1 | Begin a first start (accepted with master off) |
| restart_req | input | 1 | Begin a repeated start (accepted with master on) |
| addr_byte | input | 8 | Slave address and direction bit to send |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Sequence in progress |
| ctrl_flags | output | 4 | {master, transmit, bus-busy, pending} |
| ack_mode | output | 1 | Acknowledge mode enabled |
| data_byte | output | 8 | Loaded address/data byte |
| bus_busy | output | 1 | Bus-busy status from start/stop detection |
| lrb | output | 1 | Last bit sampled on an SCL rising edge |

## Verification
A sequencer stuck in a wait state shows up as `busy` held high with no SDA fall. The bench sees this within a few hundred cycles of the line becoming free. A timer that is loaded wrongly or never reloaded moves the SDA fall outside a window of a few cycles around the setup and hold limits. A corrupted shift register or bit count shows up as a wrong or short byte captured at the SCL rising edges. Flag-word errors are visible two edges after a request and at the start edge.

// File: rtl/i2c_rs_pkg.sv
// Package: shared state encoding, flag word layout and tick arithmetic
// for the repeated-start sequencer. Assumes integer nanosecond timings.
package i2c_rs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RELEASE,
        ST_WAIT_BB,
        ST_WAIT_LRB,
        ST_SETUP,
        ST_START,
        ST_ADDR,
        ST_DONE
    } rs_state_t;

    // Flag word: bit 3 master, bit 2 transmit, bit 1 bus-busy, bit 0 pending
    typedef struct packed {
        logic mst;
        logic trx;
        logic bb;
        logic pin;
    } rs_ctrl_t;

    // Ticks that cover ns with one extra so the first partial tick never shortens it
    function automatic int unsigned ns_to_ticks(input int unsigned ns,
                                                input int unsigned tick_ns);
        return (ns + tick_ns - 1) / tick_ns + 1;
    endfunction

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/i2c_rs_bus_mon.sv
// Bus monitor: detects start/stop conditions on the sampled lines to keep a
// bus-busy status, and latches SDA at every SCL rising edge as the last
// received bit. Assumes scl_in/sda_in are already synchronous to clk.
module i2c_rs_bus_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic bus_busy,
    output logic lrb
);
    logic scl_q, sda_q;
    logic start_seen, stop_seen, scl_rise;

    assign start_seen = scl_q & scl_in & sda_q & ~sda_in;
    assign stop_seen  = scl_q & scl_in & ~sda_q & sda_in;
    assign scl_rise   = ~scl_q & scl_in;

    // Previous line levels, idle-high after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
        end
    end

    // Bus-busy status set by a start condition, cleared by a stop condition
    always_ff @(posedge clk) begin
        if (!rst_n)          bus_busy <= 1'b0;
        else if (start_seen) bus_busy <= 1'b1;
        else if (stop_seen)  bus_busy <= 1'b0;
    end

    // Last received bit captured on each SCL rising edge
    always_ff @(posedge clk) begin
        if (!rst_n)        lrb <= 1'b1;
        else if (scl_rise) lrb <= sda_in;
    end

    // R5: lrb keeps its value when SCL did not rise
    p_lrb_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_rise) |=> $stable(lrb));

endmodule

// File: rtl/i2c_rs_tick_timer.sv
// Tick timer: loadable down counter that decrements once per tick strobe and
// reports expiry at zero. A load wins over a tick in the same cycle.
module i2c_rs_tick_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    // Down count in tick units
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (load)               cnt <= load_val;
        else if (tick && cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R6: without a tick or a load the remaining delay never moves
    p_cnt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(cnt));

endmodule

// File: rtl/i2c_rs_addr_shift.sv
// Address shifter: holds the byte being sent, exposes the bit that follows
// the current one and flags the last bit. Rotates so every bit stays live.
module i2c_rs_addr_shift #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         advance,
    output logic         next_bit,
    output logic         last
);
    localparam int unsigned LW = $clog2(W + 1);

    logic [W-1:0]  sh;
    logic [LW-1:0] left;

    // Shift register and remaining-bit count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '0;
            left <= '0;
        end else if (load) begin
            sh   <= din;
            left <= LW'(W);
        end else if (advance) begin
            sh   <= {sh[W-2:0], sh[W-1]};
            left <= left - 1'b1;
        end
    end

    assign next_bit = sh[W-2];
    assign last     = (left == LW'(1));

    // R10: never more than W bits outstanding
    p_left_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        left <= LW'(W));

endmodule

// File: rtl/i2c_restart_seq.sv
// Repeated-start sequencer (top): releases the bus without a stop, waits for
// the line to be free and the last received bit to read high, holds a setup
// delay, drives a start and shifts the address out MSB first. Assumes an
// external pull-up on both lines and a periodic tick of TICK_NS.
module i2c_restart_seq
    import i2c_rs_pkg::*;
#(
    parameter int unsigned BYTE_W   = 8,
    parameter int unsigned TICK_NS  = 100,
    parameter int unsigned SETUP_NS = 4700,
    parameter int unsigned HOLD_NS  = 4000,
    parameter int unsigned HALF_NS  = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start_req,
    input  logic              restart_req,
    input  logic [BYTE_W-1:0] addr_byte,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              busy,
    output logic [3:0]        ctrl_flags,
    output logic              ack_mode,
    output logic [BYTE_W-1:0] data_byte,
    output logic              bus_busy,
    output logic              lrb
);
    localparam int unsigned SETUP_TICKS = ns_to_ticks(SETUP_NS, TICK_NS);
    localparam int unsigned HOLD_TICKS  = ns_to_ticks(HOLD_NS, TICK_NS);
    localparam int unsigned HALF_TICKS  = ns_to_ticks(HALF_NS, TICK_NS);
    localparam int unsigned MAX_TICKS   = max3(SETUP_TICKS, HOLD_TICKS, HALF_TICKS);
    localparam int unsigned CNT_W       = $clog2(MAX_TICKS + 1);

    rs_state_t        state, state_n;
    rs_ctrl_t         ctrl_q;
    logic             phase_high;
    logic             tmr_load, tmr_expired;
    logic [CNT_W-1:0] tmr_val;
    logic             sh_load, sh_adv, sh_next, sh_last;
    logic             free_ok;
    logic             ev_arm, ev_start, ev_first, ev_edge;

    assign free_ok  = scl_in & sda_in;
    assign ev_arm   = (state == ST_WAIT_LRB) && lrb;
    assign ev_start = (state == ST_SETUP) && free_ok && tmr_expired;
    assign ev_first = (state == ST_START) && tmr_expired;
    assign ev_edge  = (state == ST_ADDR) && tmr_expired;

    i2c_rs_bus_mon u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .bus_busy (bus_busy),
        .lrb      (lrb)
    );

    i2c_rs_tick_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    i2c_rs_addr_shift #(.W(BYTE_W)) u_sh (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .din      (data_byte),
        .advance  (sh_adv),
        .next_bit (sh_next),
        .last     (sh_last)
    );

    // Next-state selection and timer/shifter strobes
    always_comb begin
        state_n  = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_adv   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (restart_req && ctrl_q.mst)     state_n = ST_RELEASE;
                else if (start_req && !ctrl_q.mst) state_n = ST_WAIT_BB;
            end
            ST_RELEASE: state_n = ST_WAIT_BB;
            ST_WAIT_BB: begin
                if (!bus_busy || scl_in) state_n = ST_WAIT_LRB;
            end
            ST_WAIT_LRB: begin
                if (lrb) begin
                    state_n  = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(SETUP_TICKS);
                end
            end
            ST_SETUP: begin
                if (!free_ok) begin
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(SETUP_TICKS);
                end else if (tmr_expired) begin
                    state_n  = ST_START;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(HOLD_TICKS);
                end
            end
            ST_START: begin
                if (tmr_expired) begin
                    state_n  = ST_ADDR;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(HALF_TICKS);
                    sh_load  = 1'b1;
                end
            end
            ST_ADDR: begin
                if (tmr_expired) begin
                    if (!phase_high) begin
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(HALF_TICKS);
                    end else if (sh_last) begin
                        state_n = ST_DONE;
                    end else begin
                        sh_adv   = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(HALF_TICKS);
                    end
                end
            end
            ST_DONE: state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Flag word, acknowledge mode and data byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '{mst: 1'b0, trx: 1'b0, bb: 1'b0, pin: 1'b1};
            ack_mode  <= 1'b0;
            data_byte <= '0;
        end else begin
            if (state == ST_RELEASE)
                ctrl_q <= '{mst: 1'b0, trx: 1'b0, bb: 1'b0, pin: 1'b1};
            else if (ev_start)
                ctrl_q <= '{mst: 1'b1, trx: 1'b1, bb: 1'b1, pin: 1'b1};
            else if (state == ST_DONE)
                ctrl_q.pin <= 1'b0;
            if (ev_arm) begin
                ack_mode  <= 1'b1;
                data_byte <= addr_byte;
            end
        end
    end

    // Open-drain line enables and clock phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_oe     <= 1'b0;
            sda_oe     <= 1'b0;
            phase_high <= 1'b0;
        end else if (state == ST_RELEASE) begin
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
        end else if (ev_start) begin
            sda_oe <= 1'b1;
        end else if (ev_first) begin
            scl_oe     <= 1'b1;
            sda_oe     <= ~data_byte[BYTE_W-1];
            phase_high <= 1'b0;
        end else if (ev_edge) begin
            if (!phase_high) begin
                scl_oe     <= 1'b0;
                phase_high <= 1'b1;
            end else begin
                scl_oe     <= 1'b1;
                phase_high <= 1'b0;
                if (!sh_last) sda_oe <= ~sh_next;
            end
        end
    end

    assign busy       = (state != ST_IDLE);
    assign ctrl_flags = ctrl_q;

    // R2: restart with master off leaves the sequencer idle
    p_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && restart_req && !start_req && !ctrl_q.mst) |=> !busy);

    // R3: release clears master/transmit/bus-busy, sets pending, frees both lines
    p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RELEASE) |=> (ctrl_flags == 4'b0001 && !scl_oe && !sda_oe));

    // R4: no progress while the bus is busy and SCL is held low
    p_wait_bb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_BB && bus_busy && !scl_in) |=> (state == ST_WAIT_BB));

    // R5: no progress while the last received bit reads 0
    p_wait_lrb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_LRB && !lrb) |=> (state == ST_WAIT_LRB));

    // R7: acknowledge mode is on whenever the start is being held
    p_ack_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START) |-> ack_mode);

    // R8: SDA pulled low with SCL released carries the all-ones flag word
    p_start_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && !scl_oe) |-> (ctrl_flags == 4'b1111));

    // R11: completion always leaves the pending flag cleared
    p_done_pin_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !ctrl_flags[0]);

endmodule

// File: tb/i2c_restart_seq_tb.sv
// Bench: pull-up line model with hold-low hooks for another device, directed
// corner cases plus seeded random restarts, checked against windows computed
// from the timing parameters.
module i2c_restart_seq_tb_top;

    localparam int TICK_DIV = 10;                 // 100 ns tick at 100 MHz
    localparam int SETUP_CYC = 470;               // 4.7 us in clocks
    localparam int HOLD_CYC  = 400;               // 4.0 us in clocks
    localparam int SETUP_MAX = (47 + 1) * TICK_DIV + 10;
    localparam int HOLD_MAX  = (40 + 1) * TICK_DIV + 5;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       start_req = 1'b0, restart_req = 1'b0;
    logic [7:0] addr_byte = 8'h00;
    logic       hold_scl = 1'b0, hold_sda = 1'b0;
    logic       scl_oe, sda_oe, busy, ack_mode, bus_busy, lrb;
    logic [3:0] ctrl_flags;
    logic [7:0] data_byte;
    wire        scl_line = ~(scl_oe | hold_scl);
    wire        sda_line = ~(sda_oe | hold_sda);

    i2c_restart_seq #(.HALF_NS(2500)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .start_req(start_req), .restart_req(restart_req), .addr_byte(addr_byte),
        .scl_in(scl_line), .sda_in(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .ctrl_flags(ctrl_flags),
        .ack_mode(ack_mode), .data_byte(data_byte), .bus_busy(bus_busy), .lrb(lrb)
    );

    int cyc = 0;
    int div = 0;
    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge clk) begin
        if (div == TICK_DIV - 1) begin div <= 0; tick <= 1'b1; end
        else begin div <= div + 1; tick <= 1'b0; end
    end

    // Line monitor: start events, first SCL fall after start, captured bits
    logic       p_scl = 1'b1, p_sda = 1'b1;
    int         last_nonfree = 0, nonfree_at_start = 0;
    int         start_cyc = 0, hold_cyc = 0, n_starts = 0, ncap = 0;
    logic [7:0] cap = 8'h00;
    logic [3:0] flags_at_start = 4'h0;
    logic       ack_at_start = 1'b0;
    logic [7:0] data_at_start = 8'h00;
    logic       in_frame = 1'b0;

    always @(negedge clk) begin
        if (p_scl && scl_line && p_sda && !sda_line) begin
            start_cyc        = cyc;
            nonfree_at_start = last_nonfree;
            n_starts++;
            in_frame         = 1'b1;
            hold_cyc         = 0;
            cap              = 8'h00;
            ncap             = 0;
            flags_at_start   = ctrl_flags;
            ack_at_start     = ack_mode;
            data_at_start    = data_byte;
        end else if (in_frame && p_scl && !scl_line && hold_cyc == 0) begin
            hold_cyc = cyc;
        end
        if (in_frame && !p_scl && scl_line) begin
            cap = {cap[6:0], sda_line};
            ncap++;
        end
        if (!(scl_line && sda_line)) last_nonfree = cyc;
        p_scl = scl_line;
        p_sda = sda_line;
    end

    int n_tests = 0, n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // mode: 0 plain, 1 SCL held low, 2 SDA held low, 3 SCL glitch during setup
    task automatic run_xfer(input logic [7:0] a, input int mode, input bit is_restart);
        int req_cyc, starts_before, el;
        @(negedge clk);
        addr_byte = a;
        if (mode == 1) hold_scl = 1'b1;
        if (mode == 2) hold_sda = 1'b1;
        in_frame = 1'b0;
        if (is_restart) restart_req = 1'b1; else start_req = 1'b1;
        req_cyc = cyc;
        starts_before = n_starts;
        @(negedge clk);
        restart_req = 1'b0;
        start_req   = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R11 busy after request", busy, 1);
        if (is_restart) begin
            chk(ctrl_flags == 4'b0001, "R3 flags after release", ctrl_flags, 1);
            chk(!scl_oe && !sda_oe, "R3 lines released", {scl_oe, sda_oe}, 0);
            chk(bus_busy == 1'b1, "R3 no stop on release", bus_busy, 1);
        end
        if (mode == 1) begin
            repeat (300) @(negedge clk);
            chk(n_starts == starts_before && !sda_oe, "R4 no start while SCL held",
                n_starts - starts_before, 0);
            hold_scl = 1'b0;
        end else if (mode == 2) begin
            repeat (300) @(negedge clk);
            chk(lrb == 1'b0, "R5 lrb took low SDA", lrb, 0);
            chk(!sda_oe && busy, "R5 no start while lrb low", sda_oe, 0);
            hold_sda = 1'b0;
            repeat (5) @(negedge clk);
            hold_scl = 1'b1;
            repeat (5) @(negedge clk);
            hold_scl = 1'b0;
        end else if (mode == 3) begin
            repeat (200) @(negedge clk);
            hold_scl = 1'b1;
            repeat (5) @(negedge clk);
            hold_scl = 1'b0;
        end
        while (busy) @(negedge clk);
        el = start_cyc - max2(nonfree_at_start, req_cyc);
        chk(n_starts == starts_before + 1, "R8 one start generated", n_starts - starts_before, 1);
        chk(el >= SETUP_CYC && el <= SETUP_MAX, "R6 setup delay", el, SETUP_CYC);
        chk(flags_at_start == 4'b1111, "R8 flags at start", flags_at_start, 15);
        chk(ack_at_start && data_at_start == a, "R7 ack mode and byte loaded",
            data_at_start, a);
        chk((hold_cyc - start_cyc) >= HOLD_CYC && (hold_cyc - start_cyc) <= HOLD_MAX,
            "R9 start hold", hold_cyc - start_cyc, HOLD_CYC);
        chk(ncap == 8 && cap == a, is_restart ? "R10 address bits" : "R12 address after first start",
            cap, a);
        chk(ctrl_flags == 4'b1110 && scl_oe, "R11 completion flags", ctrl_flags, 14);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'd20240611);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !scl_oe && !sda_oe, "R1 idle outputs", {busy, scl_oe, sda_oe}, 0);
        chk(ctrl_flags == 4'b0001 && !ack_mode, "R1 flag word", ctrl_flags, 1);
        chk(!bus_busy && lrb, "R1 monitor state", {bus_busy, lrb}, 1);
        // R2 restart with master off is ignored
        restart_req = 1'b1;
        @(negedge clk);
        restart_req = 1'b0;
        repeat (50) @(negedge clk);
        chk(!busy && ctrl_flags == 4'b0001, "R2 guard busy/flags", {busy, ctrl_flags}, 1);
        chk(!scl_oe && !sda_oe, "R2 guard lines", {scl_oe, sda_oe}, 0);
        // R12 first start from master off
        run_xfer(8'hA4, 0, 1'b0);
        // directed restarts, one per mode
        run_xfer(8'h5B, 0, 1'b1);
        run_xfer(8'hFF, 1, 1'b1);
        run_xfer(8'h00, 2, 1'b1);
        run_xfer(8'h81, 3, 1'b1);
        // seeded random restarts
        for (int i = 0; i < 6; i++) begin
            logic [7:0] a;
            int m;
            a = 8'($urandom);
            m = int'($urandom % 4);
            run_xfer(a, m, 1'b1);
        end
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule